// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Engine

This block is the interrupt side of one device function that signals through memory-write messages. It keeps a table with one entry per vector. Each entry holds a 64-bit message address, a 32-bit message data word and a mask bit. It also keeps one pending bit per vector and the function-level enable and mask-all control bits. Device logic raises an event by naming a vector index. If the vector can deliver, the block sends the entry's address and data as a single-beat write request. If the vector is masked, the event is parked in the pending bits. It is sent automatically once the vector stops being masked, whether the per-vector mask bit is cleared or the function-level mask is lifted.

Software reaches the table and the pending-bit array through a 32-bit register port that has two windows. It reaches the control byte through a config write port. Several vectors can become deliverable at the same time, for example when the function mask lifts with many bits pending. The requests then leave one at a time, lowest vector index first, through a valid/ready handshake. A pending bit stays set until its request is accepted, so the pending-bit window also shows vectors that are waiting to issue.

Top module: `msix_engine`

## Requirements
- R1: After reset the enable and mask-all bits read 0, every pending bit reads 0, every entry's address and data words read 0, every entry's control dword reads 1 (masked), and no request is valid. The control readback `cfg_ctrl` is {enable in bit 15, mask-all in bit 14, zeros in bits 13:11, N-1 in bits 10:0}.
- R2: In the table window, entry v occupies byte offsets 16v..16v+15 as four dwords: address low (+0), address high (+4), data (+8) and control (+12). Only bit 0 of the control dword (the vector mask) is stored. Its other bits read 0.
- R3: The function is masked while the enable bit (`cfg_byte` bit 7) is clear or the mask-all bit (`cfg_byte` bit 6) is set. No request becomes valid while the function is masked. An event then sets the vector's pending bit.
- R4: An event on an in-use, unmasked vector produces one request carrying {address high, address low} and the data word of that entry.
- R5: When the function mask lifts, every pending in-use vector is sent, one request per vector, in ascending index order, and each pending bit reads 0 afterwards.
- R6: Clearing a vector's own mask bit while its pending bit is set sends its message and clears the bit.
- R7: Events whose index is at or above N, or whose vector is not marked in use, change no pending bit and produce no request.
- R8: When a vector's in-use input falls, its pending bit is cleared and its parked event is never sent.
- R9: Writes to the pending-bit window have no effect. Pending bit v reads in PBA dword v/32 at bit v%32 (byte v/8, bit v%8).
- R10: `intx_clr` pulses high for the single cycle after a config write whose byte has the enable bit set. It stays low after any other cycle.
- R11: While `req_valid` is high and `req_ready` is low, the request address and data hold steady, and the vector's pending bit stays set until acceptance.
- R12: An event on the vector whose request is accepted in the same cycle leaves the pending bit set, so a second request for that vector follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register port write strobe (32-bit access) |
| reg_sel_pba | input | 1 | 0 selects the vector table window, 1 the pending-bit window |
| reg_addr | input | $clog2(N)+4 | Byte offset inside the selected window, dword aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_byte | input | 8 | Control byte: bit 7 enable, bit 6 mask-all |
| cfg_ctrl | output | 16 | Control word readback |
| intx_clr | output | 1 | Request to drop any legacy wire interrupt |
| vec_inuse | input | N | Per-vector in-use marks |
| evt_fire | input | 1 | Event strobe |
| evt_vec | input | $clog2(N)+1 | Event vector index, may exceed N-1 |
| req_valid | output | 1 | Memory-write request valid |
| req_ready | input | 1 | Memory-write request accepted |
| req_addr | output | 64 | Message address |
| req_data | output | 32 | Message data |

## Verification
The collision to provoke is an event on a vector in the same cycle that vector's outstanding request is accepted: the acceptance clears the pending bit while the event sets it. The bench holds `req_ready` low until the request is waiting, then raises ready and fires the same vector on one clock edge. It expects two identical messages in its scoreboard queue, and the monitor must see both. A second overlap is a mask release that leaves several vectors pending at once. There the queue order checks ascending delivery, and no message may be lost or duplicated.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef enum logic [1:0] {
        DW_ADDR_LO = 2'd0,
        DW_ADDR_HI = 2'd1,
        DW_DATA    = 2'd2,
        DW_CTRL    = 2'd3
    } entry_dw_e;

    localparam int CTRL_EN_BIT    = 7;
    localparam int CTRL_FMASK_BIT = 6;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    localparam vec_entry_t ENTRY_RESET = '{addr_lo: 32'd0, addr_hi: 32'd0,
                                           data: 32'd0, mask: 1'b1};

    function automatic msg_t entry_msg(input vec_entry_t e);
        msg_t m;
        m.addr = {e.addr_hi, e.addr_lo};
        m.data = e.data;
        return m;
    endfunction

    function automatic logic [31:0] entry_dword(input vec_entry_t e, input entry_dw_e sel);
        logic [31:0] d;
        case (sel)
            DW_ADDR_LO: d = e.addr_lo;
            DW_ADDR_HI: d = e.addr_hi;
            DW_DATA:    d = e.data;
            default:    d = {31'd0, e.mask};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int N_VEC = 8,
    parameter int IDXW  = $clog2(N_VEC),
    parameter int AW    = IDXW + 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [31:0]      rd_data,
    input  logic [IDXW-1:0]  sel_idx,
    output msg_t             sel_msg,
    output logic [N_VEC-1:0] vec_mask
);

    vec_entry_t ent [N_VEC];

    logic [IDXW-1:0] wr_idx;
    logic [IDXW-1:0] rd_idx;
    entry_dw_e       wr_dw;

    assign wr_idx = wr_addr[AW-1:4];
    assign rd_idx = rd_addr[AW-1:4];
    assign wr_dw  = entry_dw_e'(wr_addr[3:2]);

    always_ff @(posedge clk) begin
        for (int v = 0; v < N_VEC; v++) begin
            if (rst) begin
                ent[v] <= ENTRY_RESET;
            end else if (wr_en && (32'(wr_idx) == v)) begin
                case (wr_dw)
                    DW_ADDR_LO: ent[v].addr_lo <= wr_data;
                    DW_ADDR_HI: ent[v].addr_hi <= wr_data;
                    DW_DATA:    ent[v].data    <= wr_data;
                    default:    ent[v].mask    <= wr_data[0];
                endcase
            end
        end
    end

    always_comb begin
        rd_data = 32'd0;
        if (32'(rd_idx) < N_VEC) begin
            rd_data = entry_dword(ent[rd_idx], entry_dw_e'(rd_addr[3:2]));
        end
    end

    always_comb begin
        for (int v = 0; v < N_VEC; v++) begin
            vec_mask[v] = ent[v].mask;
        end
    end

    assign sel_msg = entry_msg(ent[sel_idx]);

endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array #(
    parameter int N_VEC = 8,
    parameter int IDXW  = $clog2(N_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDXW-1:0]  set_idx,
    input  logic             clr_en,
    input  logic [IDXW-1:0]  clr_idx,
    input  logic [N_VEC-1:0] inuse,
    output logic [N_VEC-1:0] pend
);

    logic [N_VEC-1:0] inuse_q;
    logic [N_VEC-1:0] set_vec;
    logic [N_VEC-1:0] clr_vec;
    logic [N_VEC-1:0] dropped;

    always_comb begin
        for (int v = 0; v < N_VEC; v++) begin
            set_vec[v] = set_en && (32'(set_idx) == v);
            clr_vec[v] = clr_en && (32'(clr_idx) == v);
        end
    end

    assign dropped = inuse_q & ~inuse;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            inuse_q <= '0;
        end else begin
            inuse_q <= inuse;
            // a fresh event wins over the acceptance of the previous one
            pend    <= (pend & ~clr_vec & ~dropped) | set_vec;
        end
    end

endmodule

// File: rtl/msix_issue.sv
module msix_issue
    import msix_pkg::*;
#(
    parameter int N_VEC = 8,
    parameter int IDXW  = $clog2(N_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_VEC-1:0] deliverable,
    output logic [IDXW-1:0]  sel_idx,
    input  msg_t             sel_msg,
    input  logic             req_ready,
    output logic             req_valid,
    output msg_t             req_msg,
    output logic             acc_en,
    output logic [IDXW-1:0]  acc_idx
);

    logic [IDXW-1:0]  cur_idx;
    logic [N_VEC-1:0] inflight;
    logic [N_VEC-1:0] cand;
    logic             cand_any;
    logic             load;

    always_comb begin
        inflight = '0;
        if (req_valid) inflight[cur_idx] = 1'b1;
    end

    assign cand = deliverable & ~inflight;

    always_comb begin
        sel_idx  = '0;
        cand_any = 1'b0;
        for (int v = N_VEC - 1; v >= 0; v--) begin
            if (cand[v]) begin
                sel_idx  = IDXW'(v);
                cand_any = 1'b1;
            end
        end
    end

    assign load    = cand_any && (!req_valid || req_ready);
    assign acc_en  = req_valid && req_ready;
    assign acc_idx = cur_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            cur_idx   <= '0;
            req_msg   <= '0;
        end else if (load) begin
            req_valid <= 1'b1;
            cur_idx   <= sel_idx;
            req_msg   <= sel_msg;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/msix_engine.sv
module msix_engine
    import msix_pkg::*;
#(
    parameter int N_VEC = 8,
    localparam int IDXW   = $clog2(N_VEC),
    localparam int WIN_AW = IDXW + 4,
    localparam int EVW    = IDXW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel_pba,
    input  logic [WIN_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_byte,
    output logic [15:0]       cfg_ctrl,
    output logic              intx_clr,
    input  logic [N_VEC-1:0]  vec_inuse,
    input  logic              evt_fire,
    input  logic [EVW-1:0]    evt_vec,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [63:0]       req_addr,
    output logic [31:0]       req_data
);

    localparam int PBA_DW  = (N_VEC + 31) / 32;
    localparam int PDW_IW  = WIN_AW - 2;

    logic             fn_en;
    logic             fn_maskall;
    logic             fn_masked;
    logic [N_VEC-1:0] vec_mask;
    logic [N_VEC-1:0] pend;
    logic [N_VEC-1:0] deliverable;
    logic [IDXW-1:0]  sel_idx;
    msg_t             sel_msg;
    msg_t             req_msg;
    logic             acc_en;
    logic [IDXW-1:0]  acc_idx;
    logic             evt_ok;
    logic [31:0]      tbl_rdata;
    logic [31:0]      pba_rdata;
    logic [PBA_DW*32-1:0] pend_pad;
    logic [PDW_IW-1:0]    pba_dw_idx;

    // control byte
    always_ff @(posedge clk) begin
        if (rst) begin
            fn_en      <= 1'b0;
            fn_maskall <= 1'b0;
            intx_clr   <= 1'b0;
        end else begin
            intx_clr <= cfg_wr && cfg_byte[CTRL_EN_BIT];
            if (cfg_wr) begin
                fn_en      <= cfg_byte[CTRL_EN_BIT];
                fn_maskall <= cfg_byte[CTRL_FMASK_BIT];
            end
        end
    end

    assign fn_masked = !fn_en || fn_maskall;
    assign cfg_ctrl  = {fn_en, fn_maskall, 3'b000, 11'(N_VEC - 1)};

    // event qualification
    assign evt_ok = evt_fire && (32'(evt_vec) < N_VEC) && vec_inuse[evt_vec[IDXW-1:0]];

    msix_vec_table #(.N_VEC(N_VEC), .IDXW(IDXW), .AW(WIN_AW)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr && !reg_sel_pba),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .rd_addr  (reg_addr),
        .rd_data  (tbl_rdata),
        .sel_idx  (sel_idx),
        .sel_msg  (sel_msg),
        .vec_mask (vec_mask)
    );

    msix_pend_array #(.N_VEC(N_VEC), .IDXW(IDXW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (evt_ok),
        .set_idx (evt_vec[IDXW-1:0]),
        .clr_en  (acc_en),
        .clr_idx (acc_idx),
        .inuse   (vec_inuse),
        .pend    (pend)
    );

    assign deliverable = pend & ~vec_mask & {N_VEC{!fn_masked}};

    msix_issue #(.N_VEC(N_VEC), .IDXW(IDXW)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .deliverable (deliverable),
        .sel_idx     (sel_idx),
        .sel_msg     (sel_msg),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_msg     (req_msg),
        .acc_en      (acc_en),
        .acc_idx     (acc_idx)
    );

    assign req_addr = req_msg.addr;
    assign req_data = req_msg.data;

    // pending-bit window, read only
    assign pend_pad   = (PBA_DW * 32)'(pend);
    assign pba_dw_idx = reg_addr[WIN_AW-1:2];

    always_comb begin
        pba_rdata = 32'd0;
        for (int d = 0; d < PBA_DW; d++) begin
            if (32'(pba_dw_idx) == d) pba_rdata = pend_pad[d*32 +: 32];
        end
    end

    assign reg_rdata = reg_sel_pba ? pba_rdata : tbl_rdata;

endmodule

// File: rtl/msix_engine_chk.sv
module msix_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [7:0]  cfg_byte,
    input logic [15:0] cfg_ctrl,
    input logic        intx_clr,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic [31:0] req_data
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!req_valid && cfg_ctrl[15:14] == 2'b00));

    assert_fn_masked_no_req_R3: assert property (@(posedge clk) disable iff (rst)
        ((!cfg_ctrl[15] || cfg_ctrl[14]) && !req_valid) |=> !req_valid);

    assert_intx_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_byte[7]) |=> intx_clr);

    assert_intx_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_byte[7]) |=> !intx_clr);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

endmodule

bind msix_engine msix_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_byte  (cfg_byte),
    .cfg_ctrl  (cfg_ctrl),
    .intx_clr  (intx_clr),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_data  (req_data)
);

// File: tb/tb_msix_engine.sv
module tb_msix_engine;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC  = 8;
    localparam int IDXW   = $clog2(N_VEC);
    localparam int WIN_AW = IDXW + 4;
    localparam int EVW    = IDXW + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic              reg_sel_pba = 1'b0;
    logic [WIN_AW-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_byte = '0;
    logic [15:0]       cfg_ctrl;
    logic              intx_clr;
    logic [N_VEC-1:0]  vec_inuse = '0;
    logic              evt_fire = 1'b0;
    logic [EVW-1:0]    evt_vec = '0;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [63:0]       req_addr;
    logic [31:0]       req_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [95:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msix_engine #(.N_VEC(N_VEC)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel_pba(reg_sel_pba),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_wr(cfg_wr), .cfg_byte(cfg_byte), .cfg_ctrl(cfg_ctrl),
        .intx_clr(intx_clr), .vec_inuse(vec_inuse), .evt_fire(evt_fire),
        .evt_vec(evt_vec), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data)
    );

    function automatic logic [63:0] vaddr(input int v);
        return {32'h0000_00F0 + 32'(v), 32'h1000_0000 + 32'(v * 16)};
    endfunction

    function automatic logic [31:0] vdata(input int v);
        return 32'hCAFE_0000 + 32'(v);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_msg(input int v, input string req);
        exp_q.push_back({vaddr(v), vdata(v)});
        tag_q.push_back(req);
    endtask

    // scoreboard monitor
    always begin
        @(negedge clk);
        #1;
        if (!rst && req_valid && req_ready) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3/R7 unexpected request actual=%h/%h expected=none", req_addr, req_data);
            end else begin
                logic [95:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({req_addr, req_data} !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, {req_addr, req_data}, e);
                end
            end
        end
    end

    task automatic reg_write(input logic pba, input int addr, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel_pba = pba; reg_addr = WIN_AW'(addr); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic pba, input int addr, output logic [31:0] d);
        @(negedge clk);
        reg_sel_pba = pba; reg_addr = WIN_AW'(addr);
        #1 d = reg_rdata;
    endtask

    task automatic cfg_write(input logic [7:0] b);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_byte = b;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic fire(input int v);
        @(negedge clk);
        evt_fire = 1'b1; evt_vec = EVW'(v);
        @(negedge clk);
        evt_fire = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic check_pba(input string req, input logic [31:0] exp);
        logic [31:0] d;
        reg_read(1'b1, 0, d);
        check(req, 64'(d), 64'(exp));
    endtask

    task automatic check_drained(input string req);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s actual=%0d queued expected=0", req, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] held_a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        check("R1 ctrl", 64'(cfg_ctrl), 64'h0007);
        check("R1 req_valid", 64'(req_valid), 64'd0);
        reg_read(1'b0, (3 << 4) | 12, d); check("R1 mask", 64'(d), 64'd1);
        reg_read(1'b0, (3 << 4) | 8, d);  check("R1 data", 64'(d), 64'd0);
        check_pba("R1 pba", 32'd0);

        // R2 table programming
        for (int v = 0; v < N_VEC; v++) begin
            reg_write(1'b0, (v << 4) | 0, vaddr(v)[31:0]);
            reg_write(1'b0, (v << 4) | 4, vaddr(v)[63:32]);
            reg_write(1'b0, (v << 4) | 8, vdata(v));
        end
        reg_read(1'b0, (5 << 4) | 0, d); check("R2 lo", 64'(d), 64'(vaddr(5)[31:0]));
        reg_read(1'b0, (5 << 4) | 4, d); check("R2 hi", 64'(d), 64'(vaddr(5)[63:32]));
        reg_read(1'b0, (5 << 4) | 8, d); check("R2 data", 64'(d), 64'(vdata(5)));
        reg_write(1'b0, (5 << 4) | 12, 32'hFFFF_FFFE);
        reg_read(1'b0, (5 << 4) | 12, d); check("R2 ctrl clear", 64'(d), 64'd0);
        reg_write(1'b0, (5 << 4) | 12, 32'hFFFF_FFFF);
        reg_read(1'b0, (5 << 4) | 12, d); check("R2 ctrl only bit0", 64'(d), 64'd1);
        for (int v = 0; v < N_VEC; v++) reg_write(1'b0, (v << 4) | 12, 32'd0);
        vec_inuse = 8'hBF;   // vector 6 not in use

        // R3 event while function disabled
        fire(3);
        settle();
        check_pba("R3 pend set", 32'h08);

        // R7 out of range / not in use
        fire(8);
        fire(6);
        settle();
        check_pba("R7 ignored", 32'h08);

        // R5 replay on enable in ascending order, R10 intx pulse
        fire(5);
        fire(1);
        settle();
        check_pba("R3 pend many", 32'h2A);
        expect_msg(1, "R5 order 1");
        expect_msg(3, "R5 order 3");
        expect_msg(5, "R5 order 5");
        cfg_write(8'h80);
        check("R10 intx pulse", 64'(intx_clr), 64'd1);
        @(negedge clk); #1;
        check("R10 intx one cycle", 64'(intx_clr), 64'd0);
        settle();
        check_drained("R5 drained");
        check_pba("R5 pend cleared", 32'h00);

        // R4 direct delivery
        expect_msg(2, "R4 direct");
        fire(2);
        settle();
        check_drained("R4 drained");

        // R6 per-vector unmask replay
        reg_write(1'b0, (4 << 4) | 12, 32'd1);
        fire(4);
        settle();
        check_pba("R6 pend", 32'h10);
        expect_msg(4, "R6 replay");
        reg_write(1'b0, (4 << 4) | 12, 32'd0);
        settle();
        check_drained("R6 drained");
        check_pba("R6 pend cleared", 32'h00);

        // R3 mask-all holds, R10 no pulse on disable
        cfg_write(8'hC0);
        fire(7);
        fire(0);
        settle();
        check_pba("R3 maskall pend", 32'h81);
        cfg_write(8'h40);
        check("R10 no pulse", 64'(intx_clr), 64'd0);
        settle();
        expect_msg(0, "R5 order 0");
        expect_msg(7, "R5 order 7");
        cfg_write(8'h80);
        settle();
        check_drained("R5 maskall drained");

        // R8 in-use drop clears pending
        cfg_write(8'hC0);
        fire(2);
        settle();
        check_pba("R8 pend", 32'h04);
        vec_inuse = 8'hBB;
        settle();
        check_pba("R8 cleared", 32'h00);
        vec_inuse = 8'hBF;
        cfg_write(8'h80);
        settle();
        check_drained("R8 no send");

        // R11 hold under backpressure
        req_ready = 1'b0;
        fire(1);
        settle();
        check("R11 valid", 64'(req_valid), 64'd1);
        check_pba("R11 pend held", 32'h02);
        held_a = req_addr;
        repeat (3) @(negedge clk);
        #1 check("R11 addr stable", req_addr, held_a);
        expect_msg(1, "R11 release");
        req_ready = 1'b1;
        settle();
        check_drained("R11 drained");
        check_pba("R11 cleared", 32'h00);

        // R12 event coincides with acceptance
        req_ready = 1'b0;
        fire(3);
        settle();
        expect_msg(3, "R12 first");
        expect_msg(3, "R12 second");
        @(negedge clk);
        req_ready = 1'b1; evt_fire = 1'b1; evt_vec = EVW'(3);
        @(negedge clk);
        evt_fire = 1'b0;
        settle();
        check_drained("R12 drained");
        check_pba("R12 cleared", 32'h00);

        // R9 pending window is read only
        cfg_write(8'hC0);
        fire(0);
        settle();
        reg_write(1'b1, 0, 32'h0000_0000);
        check_pba("R9 write ignored", 32'h01);
        expect_msg(0, "R9 replay");
        cfg_write(8'h80);
        settle();
        check_drained("R9 drained");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule